// File: doc/BRIEF.md
# IEC 60958 Audio Subframe Formatter

This block sits between a source of interleaved PCM samples and an HDMI audio transmitter that expects every 32-bit word to carry its own framing. For each incoming sample it produces one subframe word: a flag byte holding block-start, parity, channel-status, user and validity bits, followed by a 24-bit audio field. It counts channels within a frame and frames within a 192-frame block, and builds the consumer channel-status word internally. The channel-number field of that word is filled with each subframe's own position, so every channel announces its own number.

Samples enter on a valid/ready stream and words leave on a valid/ready stream, one word per sample, with one register stage in between. The channel count, sample-rate code and word-length mode are captured while the block is idle, meaning from reset or from a stream-start pulse until the first sample is taken. A stream-start pulse realigns the block position to frame 0, channel 0.

Top module: `iec_subframe_fmt`

## Requirements
- R1: Every output word has bits 31..29 at zero, the block-start flag at bit 28, parity at bit 27, channel status at bit 26, user at bit 25 and validity at bit 24, both of the last two always 0; bits 23..0 hold the audio field.
- R2: With `cfg_wide` = 0 (16-bit mode), `in_data[15:0]` appears in bits 23..8, bits 7..0 are zero and `in_data[23:16]` is ignored; with `cfg_wide` = 1 (24-bit mode), `in_data[23:0]` appears unchanged in bits 23..0.
- R3: The channel count is 2*(`cfg_pairs`+1). The channel position advances on each accepted sample and wraps after the last channel, at which point the frame index advances, wrapping from 191 to 0; the block-start flag is 1 exactly for the subframes of frame index 0.
- R4: For frame index i below 42 the channel-status flag equals bit i of the channel-status word; for i of 42 or more it is 0.
- R5: Channel-status word layout: bit 2 is 1; bits 19..16 hold the channel count; bits 23..20 hold the subframe's channel number counted from 1; bits 27..24 hold the sample-rate code; bits 35..32 hold the word-length code, 0x2 in 16-bit mode and 0xB in 24-bit mode; bits 39..36 hold the original-rate code; all other bits 0..41 are 0.
- R6: `cfg_rate` selects the rate/original-rate code pair: 0 = 32 kHz (0x3/0xC), 1 = 44.1 kHz (0x0/0xF), 2 = 48 kHz (0x2/0xD), 3 = 88.2 kHz (0x8/0x7), 4 = 96 kHz (0xA/0x5), 5 = 176.4 kHz (0xC/0x3), 6 = 192 kHz (0xE/0x1), 7 = same as 48 kHz.
- R7: Parity makes bits 27..0 of every word even: bit 27 is the XOR of bits 26..0.
- R8: `in_ready` is low while a word is held with `out_ready` low; a held word stays stable until taken, and each accepted sample yields exactly one word, in order, on the cycle after acceptance.
- R9: After reset `out_valid` is 0 and the position is frame 0, channel 0 under the default configuration (stereo, 48 kHz, 16-bit). A `start` pulse returns the position to frame 0, channel 0, discards any pending output word and holds `in_ready` low during the pulse.
- R10: Configuration inputs are captured only while idle (after reset or `start`, until the first sample is accepted); changes after that have no effect until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Stream-start pulse: realign position, drop pending word, return to idle |
| cfg_pairs | input | 2 | Channel pairs minus one (2, 4, 6 or 8 channels) |
| cfg_rate | input | 3 | Sample-rate selector |
| cfg_wide | input | 1 | 0 = 16-bit samples, 1 = 24-bit samples |
| in_valid | input | 1 | Sample valid |
| in_ready | output | 1 | Sample accepted when high together with in_valid |
| in_data | input | 24 | PCM sample, channels interleaved within a frame |
| out_valid | output | 1 | Subframe word valid |
| out_ready | input | 1 | Downstream takes the word |
| out_word | output | 32 | Formatted subframe word |

## Verification
The situation hardest to reach from the ports is the channel-status content late in a block under a configuration that was changed after streaming began: the rate and word-length fields only surface in frames 24 to 39, so a configuration fault stays invisible for dozens of frames. The bench streams continuous samples well past frame 40 for every rate code and both word lengths, and in one scenario alters all configuration inputs two samples into a stream, then keeps comparing every word through frame 40 against the configuration captured at the start. Stall and restart cases are placed at mid-frame positions so that a lost or duplicated sample shifts the channel numbers and shows up in the next word.

// File: rtl/iecfmt_pkg.sv
// Shared types and code tables for the IEC 60958 subframe formatter.
// Assumes a 24-bit audio field and an 8-bit flag byte per subframe.
package iecfmt_pkg;

    localparam int unsigned FLAG_W = 8;

    // Flag byte sitting above the audio field, most significant first.
    typedef struct packed {
        logic [2:0] zero;
        logic       bstart;
        logic       parity;
        logic       chstat;
        logic       user;
        logic       valid;
    } flags_t;

    // Pair of rate codes carried in the channel-status word.
    typedef struct packed {
        logic [3:0] fs;
        logic [3:0] orig_fs;
    } rate_codes_t;

    // Map the rate selector onto its sampling and original-rate codes.
    function automatic rate_codes_t rate_lookup(input logic [2:0] sel);
        rate_codes_t r;
        case (sel)
            3'd0:    r = '{fs: 4'h3, orig_fs: 4'hC};
            3'd1:    r = '{fs: 4'h0, orig_fs: 4'hF};
            3'd3:    r = '{fs: 4'h8, orig_fs: 4'h7};
            3'd4:    r = '{fs: 4'hA, orig_fs: 4'h5};
            3'd5:    r = '{fs: 4'hC, orig_fs: 4'h3};
            3'd6:    r = '{fs: 4'hE, orig_fs: 4'h1};
            default: r = '{fs: 4'h2, orig_fs: 4'hD};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/iecfmt_pos.sv
// Block position tracker: channel slot within a frame and frame index
// within a block. Advances once per accepted sample.
// Assumes MAX_PAIRS >= 2 and a pairs setting that changes only while the
// counters sit at zero.
module iecfmt_pos #(
    parameter int unsigned FRAMES    = 192,
    parameter int unsigned MAX_PAIRS = 4,
    localparam int unsigned FIDX_W   = $clog2(FRAMES),
    localparam int unsigned PAIR_W   = $clog2(MAX_PAIRS),
    localparam int unsigned CH_W     = PAIR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    input  logic [PAIR_W-1:0] pairs,
    output logic [FIDX_W-1:0] fidx,
    output logic [CH_W-1:0]   ch
);

    logic [CH_W-1:0] last_ch;

    // Last channel slot of a frame is 2*pairs+1.
    always_comb last_ch = {pairs, 1'b1};

    // Step the channel slot, and the frame index on a frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            fidx <= '0;
            ch   <= '0;
        end else if (adv) begin
            if (ch == last_ch) begin
                ch   <= '0;
                fidx <= (fidx == FIDX_W'(FRAMES - 1)) ? '0 : fidx + FIDX_W'(1);
            end else begin
                ch <= ch + CH_W'(1);
            end
        end
    end

    AST_FIDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(fidx) < FRAMES);                                            // R3
    AST_CH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ch <= last_ch);                                                 // R3
    AST_FIDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && ch == last_ch && fidx == FIDX_W'(FRAMES - 1)) |=> fidx == '0); // R3

endmodule

// File: rtl/iecfmt_cs.sv
// Channel-status bit source: builds the consumer channel-status word for
// the current subframe and picks the bit addressed by the frame index.
// Assumes CS_BITS is at least 40 and no larger than the block length.
module iecfmt_cs
    import iecfmt_pkg::*;
#(
    parameter int unsigned CS_BITS = 42,
    parameter int unsigned FIDX_W  = 8,
    parameter int unsigned PAIR_W  = 2,
    localparam int unsigned CH_W   = PAIR_W + 1
) (
    input  logic [FIDX_W-1:0] fidx,
    input  logic [CH_W-1:0]   ch,
    input  logic [PAIR_W-1:0] pairs,
    input  logic [2:0]        rate,
    input  logic              wide,
    output logic              cbit
);

    logic [CS_BITS-1:0] cs;
    logic [3:0]         nch;
    rate_codes_t        rc;

    // Assemble the channel-status word for this subframe.
    always_comb begin
        nch = (4'(pairs) + 4'd1) << 1;
        rc  = rate_lookup(rate);
        cs  = '0;
        cs[2]     = 1'b1;
        cs[19:16] = nch;
        cs[23:20] = 4'(ch) + 4'd1;
        cs[27:24] = rc.fs;
        cs[35:32] = wide ? 4'hB : 4'h2;
        cs[39:36] = rc.orig_fs;
    end

    // Select the bit for this frame; frames past the word carry zero.
    always_comb begin
        cbit = 1'b0;
        for (int k = 0; k < CS_BITS; k++) begin
            if (fidx == FIDX_W'(k)) cbit = cs[k];
        end
    end

endmodule

// File: rtl/iecfmt_pack.sv
// Subframe packer: aligns the sample into the 24-bit field and prepends
// the flag byte with even parity over everything below the parity bit.
// Assumes SMP_W is 24.
module iecfmt_pack
    import iecfmt_pkg::*;
#(
    parameter int unsigned SMP_W  = 24,
    localparam int unsigned WORD_W = FLAG_W + SMP_W
) (
    input  logic [SMP_W-1:0]  data,
    input  logic              wide,
    input  logic              bstart,
    input  logic              cbit,
    output logic [WORD_W-1:0] word
);

    logic [SMP_W-1:0] smp;
    flags_t           fl;

    // Left-justify short samples, pass full-width ones through.
    always_comb smp = wide ? data : {data[SMP_W-9:0], 8'h00};

    // Build the flag byte and join it to the audio field.
    always_comb begin
        fl.zero   = 3'b000;
        fl.bstart = bstart;
        fl.chstat = cbit;
        fl.user   = 1'b0;
        fl.valid  = 1'b0;
        fl.parity = (^smp) ^ fl.chstat ^ fl.user ^ fl.valid;
        word      = {fl, smp};
    end

endmodule

// File: rtl/iec_subframe_fmt.sv
// IEC 60958 subframe formatter top: accepts interleaved PCM samples and
// emits one framed 32-bit word per sample through a single output register.
// Assumes configuration is held steady around a start pulse; it is
// captured while idle and frozen once streaming begins.
module iec_subframe_fmt
    import iecfmt_pkg::*;
#(
    parameter int unsigned FRAMES    = 192,
    parameter int unsigned CS_BITS   = 42,
    parameter int unsigned MAX_PAIRS = 4,
    parameter int unsigned SMP_W     = 24,
    localparam int unsigned PAIR_W   = $clog2(MAX_PAIRS),
    localparam int unsigned CH_W     = PAIR_W + 1,
    localparam int unsigned FIDX_W   = $clog2(FRAMES),
    localparam int unsigned WORD_W   = FLAG_W + SMP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PAIR_W-1:0] cfg_pairs,
    input  logic [2:0]        cfg_rate,
    input  logic              cfg_wide,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [SMP_W-1:0]  in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_word
);

    logic              idle_q;
    logic [PAIR_W-1:0] pairs_q;
    logic [2:0]        rate_q;
    logic              wide_q;
    logic              accept;
    logic [FIDX_W-1:0] fidx;
    logic [CH_W-1:0]   ch;
    logic              cbit;
    logic [WORD_W-1:0] word_nxt;

    // Take a sample when the output slot is free or being emptied.
    always_comb begin
        in_ready = !start && (!out_valid || out_ready);
        accept   = in_valid && in_ready;
    end

    // Track idle: set by reset or start, cleared by the first sample.
    always_ff @(posedge clk) begin
        if (!rst_n || start) idle_q <= 1'b1;
        else if (accept)     idle_q <= 1'b0;
    end

    // Capture configuration only while idle or on a start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pairs_q <= '0;
            rate_q  <= 3'd2;
            wide_q  <= 1'b0;
        end else if (idle_q || start) begin
            pairs_q <= cfg_pairs;
            rate_q  <= cfg_rate;
            wide_q  <= cfg_wide;
        end
    end

    iecfmt_pos #(
        .FRAMES    (FRAMES),
        .MAX_PAIRS (MAX_PAIRS)
    ) u_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .adv   (accept),
        .pairs (pairs_q),
        .fidx  (fidx),
        .ch    (ch)
    );

    iecfmt_cs #(
        .CS_BITS (CS_BITS),
        .FIDX_W  (FIDX_W),
        .PAIR_W  (PAIR_W)
    ) u_cs (
        .fidx  (fidx),
        .ch    (ch),
        .pairs (pairs_q),
        .rate  (rate_q),
        .wide  (wide_q),
        .cbit  (cbit)
    );

    iecfmt_pack #(
        .SMP_W (SMP_W)
    ) u_pack (
        .data   (in_data),
        .wide   (wide_q),
        .bstart (fidx == '0),
        .cbit   (cbit),
        .word   (word_nxt)
    );

    // Output register: load on accept, drop when taken or on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else if (start) begin
            out_valid <= 1'b0;
        end else if (accept) begin
            out_valid <= 1'b1;
            out_word  <= word_nxt;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_word))); // R8
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_word[31:29] == 3'b000 && out_word[25:24] == 2'b00)); // R1
    AST_EVEN_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (^out_word[27:0] == 1'b0));                       // R7
    AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !out_valid);                                          // R9
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_q && !start) |=> ($stable(pairs_q) && $stable(rate_q) && $stable(wide_q))); // R10

endmodule

// File: tb/iec_subframe_fmt_test.sv
// Directed bench for the subframe formatter; each task checks its own words.
module iec_subframe_fmt_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  cfg_pairs = 2'd0;
    logic [2:0]  cfg_rate = 3'd2;
    logic        cfg_wide = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [23:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_word;

    int total = 0;
    int bad = 0;
    int m_fidx = 0, m_ch = 0, m_pairs = 0, m_rate = 2;
    bit m_wide = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    iec_subframe_fmt uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .cfg_pairs (cfg_pairs),
        .cfg_rate  (cfg_rate),
        .cfg_wide  (cfg_wide),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_word  (out_word)
    );

    function automatic logic [31:0] model_word(int fidx, int ch, int pairs, int rate,
                                               bit wide, logic [23:0] d);
        logic [41:0] cs;
        logic [3:0]  fs, ofs;
        logic [23:0] s;
        logic        b, c, p;
        case (rate)
            0: begin fs = 4'h3; ofs = 4'hC; end
            1: begin fs = 4'h0; ofs = 4'hF; end
            3: begin fs = 4'h8; ofs = 4'h7; end
            4: begin fs = 4'hA; ofs = 4'h5; end
            5: begin fs = 4'hC; ofs = 4'h3; end
            6: begin fs = 4'hE; ofs = 4'h1; end
            default: begin fs = 4'h2; ofs = 4'hD; end
        endcase
        cs = '0;
        cs[2]     = 1'b1;
        cs[19:16] = 4'(2 * (pairs + 1));
        cs[23:20] = 4'(ch + 1);
        cs[27:24] = fs;
        cs[35:32] = wide ? 4'hB : 4'h2;
        cs[39:36] = ofs;
        c = (fidx < 42) ? cs[fidx] : 1'b0;
        b = (fidx == 0);
        s = wide ? d : {d[15:0], 8'h00};
        p = ^{s, c};
        return {3'b000, b, p, c, 2'b00, s};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step();
        if (m_ch == 2 * (m_pairs + 1) - 1) begin
            m_ch = 0;
            m_fidx = (m_fidx == 191) ? 0 : m_fidx + 1;
        end else begin
            m_ch++;
        end
    endtask

    // Configure, pulse start and realign the model.
    task automatic restart(int pairs, int rate, bit wide);
        @(negedge clk);
        cfg_pairs = 2'(pairs);
        cfg_rate  = 3'(rate);
        cfg_wide  = wide;
        m_pairs = pairs; m_rate = rate; m_wide = wide;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        m_fidx = 0; m_ch = 0;
    endtask

    // Stream n samples back to back; check each word one cycle later.
    task automatic stream(int n, int seed, string req);
        logic [31:0] exp_prev = '0;
        for (int i = 0; i <= n; i++) begin
            @(negedge clk);
            if (i > 0) begin
                chk({req, " valid"}, {31'b0, out_valid}, 32'd1);
                chk(req, out_word, exp_prev);
            end
            if (i < n) begin
                in_data  = 24'((i * 32'h9E37 + seed) ^ (i << 13));
                in_valid = 1'b1;
                exp_prev = model_word(m_fidx, m_ch, m_pairs, m_rate, m_wide, in_data);
                model_step();
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R9 reset out_valid", {31'b0, out_valid}, 32'd0);
        chk("R8 reset in_ready", {31'b0, in_ready}, 32'd1);
        // default configuration after reset: stereo, 48 kHz, 16-bit
        m_pairs = 0; m_rate = 2; m_wide = 0; m_fidx = 0; m_ch = 0;
        stream(6, 5, "R9 default R1 R2");
    endtask

    task automatic t_stereo16();
        restart(0, 2, 1'b0);
        stream(2 * 194, 17, "R1 R2 R3 R4 R5 R7 stereo16 wrap");
    endtask

    task automatic t_eight24();
        restart(3, 6, 1'b1);
        stream(8 * 44, 91, "R2 R4 R5 eight24");
    endtask

    task automatic t_rates();
        for (int r = 0; r < 8; r++) begin
            restart(2, r, r[0]);
            stream(6 * 42, 300 + r, "R6 R5 rate");
        end
    endtask

    task automatic t_stall();
        logic [31:0] ea, eb;
        restart(0, 2, 1'b0);
        @(negedge clk);
        out_ready = 1'b0;
        in_data   = 24'h5A1234;
        in_valid  = 1'b1;
        ea = model_word(m_fidx, m_ch, m_pairs, m_rate, m_wide, in_data);
        model_step();
        @(negedge clk);
        in_data = 24'h00BEEF;
        eb = model_word(m_fidx, m_ch, m_pairs, m_rate, m_wide, in_data);
        for (int k = 0; k < 3; k++) begin
            chk("R8 stall valid", {31'b0, out_valid}, 32'd1);
            chk("R8 stall word", out_word, ea);
            chk("R8 stall in_ready", {31'b0, in_ready}, 32'd0);
            @(negedge clk);
        end
        out_ready = 1'b1;
        model_step();
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 after stall word", out_word, eb);
        stream(6, 700, "R8 after stall no loss");
    endtask

    task automatic t_cfg_frozen();
        restart(0, 4, 1'b1);
        stream(2, 800, "R10 before change");
        @(negedge clk);
        cfg_pairs = 2'd3;
        cfg_rate  = 3'd0;
        cfg_wide  = 1'b0;
        stream(2 * 41, 900, "R10 config ignored");
        cfg_pairs = 2'(m_pairs);
        cfg_rate  = 3'(m_rate);
        cfg_wide  = m_wide;
    endtask

    task automatic t_start();
        restart(0, 2, 1'b0);
        stream(3, 1000, "R9 pre-start");
        @(negedge clk);
        start    = 1'b1;
        in_valid = 1'b1;
        in_data  = 24'h777777;
        #1;
        chk("R9 in_ready during start", {31'b0, in_ready}, 32'd0);
        @(negedge clk);
        start    = 1'b0;
        in_valid = 1'b0;
        m_fidx = 0; m_ch = 0;
        chk("R9 out_valid after start", {31'b0, out_valid}, 32'd0);
        stream(4, 1100, "R9 R3 realigned");
        // pending word dropped by start
        @(negedge clk);
        out_ready = 1'b0;
        in_valid  = 1'b1;
        in_data   = 24'h123456;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9 pending valid", {31'b0, out_valid}, 32'd1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        out_ready = 1'b1;
        m_fidx = 0; m_ch = 0;
        chk("R9 pending dropped", {31'b0, out_valid}, 32'd0);
        stream(2, 1200, "R9 R3 after drop");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_stereo16();
        t_eight24();
        t_rates();
        t_stall();
        t_cfg_frozen();
        t_start();
        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule